// File: doc/BRIEF.md
# IR Carrier Cycle Counter

This block counts carrier cycles on a raw, non-demodulated infrared receive line. A receive front end samples the line straight from the photodiode stage, so that during a mark the line toggles at the remote's carrier rate. It also supplies a separate `ir_pulse` flag that is high while the receiver is inside a mark. The counter adds one for every rising edge of the synchronised line that arrives while `ir_pulse` is high. Software sums the mark durations it measured by other means and divides the count by that time to estimate the carrier frequency. The division happens in software, not here.

Software drives the block through a small byte-wide register port. Offset 0 is a control register with these bits:

- bit 0: count enable.
- bit 1: clear-and-hold.
- bit 2: transmit polarity flip.
- bit 3: receive polarity flip.

The count is 16 bits wide by default. It is read as a low byte at offset 1 and a high byte at offset 2. Reading the low byte latches the high byte into a shadow register, so that a low-then-high read pair always gives one consistent value. The count saturates at all-ones instead of wrapping. A count of zero or of all-ones is not a usable result, and the `cnt_valid` output marks the usable ones. To restart a measurement, software writes the clear bit with enable low, then writes enable with clear low.

Top module: `ir_carrier_counter`

## Requirements
- R1: After reset the control register reads 0, both count bytes read 0, `cnt_valid` is low and `reg_rdata` is 0.
- R2: A write to offset 0 stores the control field in bits 3:0. A later read of offset 0 returns it, with any bits above bit 3 reading zero.
- R3: While enable (control bit 0) is 1 and clear (control bit 1) is 0, the count rises by exactly one for each rising edge of the effective receive line that is seen while `ir_pulse` is high.
- R4: Rising edges seen while `ir_pulse` is low leave the count unchanged.
- R5: While enable is 0, the count holds its value whatever the receive line does.
- R6: While clear is 1, the count is forced to zero and held there, even with enable set. Writing clear with enable low and then writing enable with clear low restarts counting from zero.
- R7: The count saturates at all-ones. Further edges leave it at all-ones.
- R8: A read of offset 1 returns the low byte of the count and latches the high byte into a shadow register. A read of offset 2 returns that shadow, not the live high byte.
- R9: When control bit 3 is 1, the receive line is inverted before synchronisation, so a falling edge of `ir_rx_raw` is counted and a rising edge is not.
- R10: `ir_tx_out` equals `ir_tx_in` XOR control bit 2, with no clock delay.
- R11: Read data is registered. `reg_rdata` changes on the clock edge that samples `reg_rd` high, holds its value while `reg_rd` is low, and reads zero for offset 3.
- R12: `cnt_valid` is high exactly when the count is neither zero nor all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 count low, 2 count high |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe; data appears after the next edge |
| reg_rdata | output | DATA_W | Registered read data |
| ir_rx_raw | input | 1 | Raw, asynchronous receive line carrying the carrier |
| ir_pulse | input | 1 | Synchronous mark flag from the receive front end |
| ir_tx_in | input | 1 | Transmit line before the polarity option |
| ir_tx_out | output | 1 | Transmit line after the polarity option |
| cnt_valid | output | 1 | Count is neither zero nor all-ones |

## Verification
The counting path is swept over every edge count from zero to a dozen, and then driven past saturation in a narrow configuration whose count is eight bits. This separates correct counting from an off-by-one and separates saturation from wrap-around. Three patterns each isolate one gate on the count: bursts split between marks and spaces test the `ir_pulse` gate, bursts with enable low test the enable gate, and bursts with clear and enable both set test the clear gate. Single transitions with the receive polarity flipped show whether the counted edge is the falling one of the raw line. A low read followed by more counting and then a high read shows whether the high byte comes from the shadow or from the live count.

// File: rtl/ircc_pkg.sv
package ircc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_LO = 2'd1,
    REG_CNT_HI = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic rx_flip;
    logic tx_flip;
    logic clr;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = 4;
endpackage

// File: rtl/ir_edge_sync.sv
module ir_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic flip,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], raw ^ flip};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R3
  rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/carrier_cnt.sv
module carrier_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             valid
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt <= '0;
    else if (clr)                            cnt <= '0;
    else if (en && step && cnt != ALL_ONES)  cnt <= cnt + 1'b1;
  end

  assign valid = (cnt != '0) && (cnt != ALL_ONES);

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == ALL_ONES && !clr) |=> cnt == ALL_ONES);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ir_carrier_regs.sv
module ir_carrier_regs
  import ircc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0]   shadow_hi;
  logic [DATA_W-1:0] ctrl_word;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(reg_addr);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_W-1:0] = ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (reg_wr && sel == REG_CTRL) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      shadow_hi <= '0;
    end else if (reg_rd) begin
      unique case (sel)
        REG_CTRL:   reg_rdata <= ctrl_word;
        REG_CNT_LO: begin
          reg_rdata <= cnt[DATA_W-1:0];
          shadow_hi <= cnt[CNT_W-1:DATA_W];
        end
        REG_CNT_HI: reg_rdata <= DATA_W'(shadow_hi);
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  // R8
  lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == REG_CNT_LO) |=> reg_rdata == $past(cnt[DATA_W-1:0]));
endmodule

// File: rtl/ir_carrier_counter.sv
module ir_carrier_counter
  import ircc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ir_rx_raw,
  input  logic              ir_pulse,
  input  logic              ir_tx_in,
  output logic              ir_tx_out,
  output logic              cnt_valid
);
  localparam int CNT_W = 2 * DATA_W;

  ctrl_t            ctrl;
  logic             rise;
  logic [CNT_W-1:0] cnt;

  ir_carrier_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cnt(cnt), .ctrl(ctrl)
  );

  ir_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(ir_rx_raw), .flip(ctrl.rx_flip),
    .rise(rise)
  );

  carrier_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .clr(ctrl.clr),
    .step(rise & ir_pulse), .cnt(cnt), .valid(cnt_valid)
  );

  assign ir_tx_out = ir_tx_in ^ ctrl.tx_flip;
endmodule

// File: tb/tb_ir_carrier_counter.sv
`timescale 1ns/1ps
module tb_ir_carrier_counter;
  localparam int DW  = 4;
  localparam int ALL = 255;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [1:0]    reg_addr = 0;
  logic          reg_wr = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic          reg_rd = 0;
  logic [DW-1:0] reg_rdata;
  logic          ir_rx_raw = 0;
  logic          ir_pulse = 1;
  logic          ir_tx_in = 0;
  logic          ir_tx_out;
  logic          cnt_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ir_carrier_counter #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ir_rx_raw(ir_rx_raw), .ir_pulse(ir_pulse), .ir_tx_in(ir_tx_in),
    .ir_tx_out(ir_tx_out), .cnt_valid(cnt_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 2'(a); reg_wdata = DW'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_addr = 2'(a); reg_rd = 1;
    @(negedge clk); reg_rd = 0; v = int'(reg_rdata);
  endtask

  task automatic read_cnt(output int v);
    int lo, hi;
    rd(1, lo); rd(2, hi);
    v = hi * 16 + lo;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic restart(input int flags);
    wr(2 | flags, 0); wr(0, 2 | flags);
    settle();
    wr(0, 1 | flags);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ir_rx_raw = 1;
      @(negedge clk);
      @(negedge clk); ir_rx_raw = 0;
      @(negedge clk);
    end
    settle();
  endtask

  initial begin
    int v, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", int'(reg_rdata), 0);
    check("R1 valid", int'(cnt_valid), 0);
    rd(0, v); check("R1 ctrl", v, 0);
    read_cnt(v); check("R1 count", v, 0);
    // R2 control readback
    wr(0, 4'h5); rd(0, v); check("R2 ctrl", v, 5);
    wr(0, 4'hA); rd(0, v); check("R2 ctrl", v, 10);
    // R10 transmit polarity
    wr(0, 0);
    ir_tx_in = 1; #1 check("R10 pass", int'(ir_tx_out), 1);
    wr(0, 4); ir_tx_in = 0; #1 check("R10 flip", int'(ir_tx_out), 1);
    ir_tx_in = 1; #1 check("R10 flip", int'(ir_tx_out), 0);
    wr(0, 0);
    // R3 R6 R12 sweep
    for (int n = 0; n <= 12; n++) begin
      restart(0); edges(n); read_cnt(v);
      check("R3 sweep", v, n);
      check("R12 valid", int'(cnt_valid), (n != 0) ? 1 : 0);
    end
    // R4 gating by pulse flag
    restart(0); ir_pulse = 0; settle(); edges(7); read_cnt(v);
    check("R4 space", v, 0);
    ir_pulse = 1; edges(3); ir_pulse = 0; edges(5); ir_pulse = 1; edges(2);
    read_cnt(v); check("R4 mixed", v, 5);
    // R5 enable low holds
    restart(0); edges(4); wr(0, 0); edges(6); read_cnt(v);
    check("R5 hold", v, 4);
    // R6 clear wins over enable
    wr(0, 3); settle(); read_cnt(v); check("R6 clear", v, 0);
    edges(3); read_cnt(v); check("R6 clear held", v, 0);
    wr(0, 1); edges(2); read_cnt(v); check("R6 restart", v, 2);
    // R7 saturation
    restart(0); edges(254); read_cnt(v); check("R7 254", v, 254);
    check("R12 254", int'(cnt_valid), 1);
    edges(1); read_cnt(v); check("R7 255", v, ALL);
    check("R12 all-ones", int'(cnt_valid), 0);
    edges(40); read_cnt(v); check("R7 saturate", v, ALL);
    // R8 shadow
    restart(0); edges(20); rd(1, v); check("R8 lo", v, 4);
    edges(20); rd(2, w); check("R8 shadow hi", w, 1);
    read_cnt(v); check("R8 fresh", v, 40);
    // R9 receive inversion
    restart(8); read_cnt(v); check("R9 start", v, 0);
    @(negedge clk); ir_rx_raw = 1; settle(); read_cnt(v);
    check("R9 raw rise", v, 0);
    @(negedge clk); ir_rx_raw = 0; settle(); read_cnt(v);
    check("R9 raw fall", v, 1);
    // R11 unmapped, hold
    rd(3, v); check("R11 unmapped", v, 0);
    rd(0, v); repeat (3) @(negedge clk);
    check("R11 hold", int'(reg_rdata), v);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule